// File: doc/BRIEF.md
# SPI Memory Status Register and Write-Protect Gate

This block holds the 8-bit status register of a serial non-volatile memory and decides, for each decoded write-type command, whether it may run. The serial front end hands it one event per completed command at the moment chip select rises. Each event carries a command kind, the target array address, the status data byte, and a flag that says whether the transfer ended on a whole byte. The block answers with a one-cycle accept or reject strobe. An accepted command starts a self-timed write cycle. While that cycle runs, the busy flag (WIP) is high and every new event is dropped.

Protection works in three layers. First, the write-enable latch must be armed before any write. Second, two block-protect bits fence off the top quarter, the top half or the whole array. Third, a status-register write-disable bit, combined with a low protect pin, freezes the status register itself. The block also serialises the live status byte, MSB first, for a read-status transfer. It keeps repeating that byte for as long as the front end asks for more bits.

The controller has two states. In `ST_READY` it evaluates events. On an accepted write it takes the transition *start_cycle* into `ST_CYCLE`. In `ST_CYCLE` a down-counter measures the write time. When the counter reaches zero, the transition *cycle_done* commits any pending status bits, clears the write-enable latch and returns to `ST_READY`.

Top module: `spi_wprot_ctrl`

## Requirements
- R1: `status_byte` is {SRWD, 0, 0, 0, BP1, BP0, WEL, WIP}. Bit 7 is the write-disable bit, bits 3:2 are the protect bits, bit 1 is the write-enable latch and bit 0 is busy. Bits 6:4 always read 0, and every bit is 0 after reset.
- R2: `cmd_kind` codes are: 0 none, 1 set-enable, 2 clear-enable, 3 status write, 4 array write, 5 sector write, 6 sector lock. Codes 3 to 6 are write-type. In `ST_READY`, a byte-aligned set-enable sets WEL and a byte-aligned clear-enable clears it, one cycle after `cmd_valid`, and neither produces a strobe.
- R3: An accepted status write changes only bits 7, 3 and 2, copying them from `cmd_data` bits 7, 3 and 2. The new values appear at the end of the write cycle.
- R4: A status write is rejected when SRWD=1 and `wp_n`=0. With `wp_n`=1 the same write is accepted.
- R5: An array write is rejected when its address lies in the protected range. With a 14-bit address the ranges are: BP=01 protects 3000h-3FFFh, BP=10 protects 2000h-3FFFh, BP=11 protects everything, and BP=00 protects nothing.
- R6: A sector write or a sector lock is rejected when BP=11. Otherwise the sector is not range-checked.
- R7: A write-type command with `byte_aligned`=0 is rejected.
- R8: An accepted command pulses `accept` for one cycle, one cycle after `cmd_valid`. WIP stays high for exactly `WCYC_CLKS` cycles starting in that same cycle, and WEL reads 0 once WIP falls.
- R9: While WIP=1, every command is ignored. No strobe is produced and WEL does not change.
- R10: A rejected command pulses `reject` for one cycle, one cycle after `cmd_valid`, and clears WEL at the same time.
- R11: After `rd_start`, `rd_bit` presents status bit 7. Each `rd_shift` moves to the next lower bit, and bit 0 is followed by bit 7 again.
- R12: A write-type command with WEL=0 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle event marking a completed command |
| cmd_kind | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Array address of the command |
| cmd_data | input | 8 | Data byte for a status write |
| byte_aligned | input | 1 | Chip select rose on a whole byte |
| wp_n | input | 1 | Write-protect pin, active low |
| rd_start | input | 1 | Begin a status read-out |
| rd_shift | input | 1 | Advance the read-out by one bit |
| rd_bit | output | 1 | Current serial status bit |
| status_byte | output | 8 | Live status register |
| accept | output | 1 | Write command accepted |
| reject | output | 1 | Write command refused |
| busy | output | 1 | Self-timed write cycle running |

## Verification
Directed sequences cover the following cases:
- Each block-protect level, with addresses just below and just above its range boundary, which separates the quarter decode from the half decode.
- The write-disable bit combined with both pin levels.
- Writes issued without the latch armed.
- Writes that end off a byte boundary.
- Commands sent during a running cycle, which checks that they are ignored rather than rejected.

Random sequences then mix all command kinds, pin levels and alignment against a bench model of the register. This exposes ordering faults, such as the latch clearing too early or status bits committing at the wrong time. A ten-bit read-out checks the MSB-first order and the wrap from bit 0 back to bit 7.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_WRDI  = 3'd2,
        CMD_WRSR  = 3'd3,
        CMD_ARRAY = 3'd4,
        CMD_SECT  = 3'd5,
        CMD_LOCK  = 3'd6,
        CMD_RSVD  = 3'd7
    } cmd_kind_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_CYCLE = 1'b1
    } wp_state_e;

    typedef struct packed {
        logic       srwd;
        logic [1:0] bp;
    } nv_bits_t;

    localparam int SR_SRWD = 7;
    localparam int SR_BP1  = 3;
    localparam int SR_BP0  = 2;

    function automatic logic is_write_type(input cmd_kind_e k);
        return (k == CMD_WRSR) || (k == CMD_ARRAY) || (k == CMD_SECT) || (k == CMD_LOCK);
    endfunction

    function automatic logic [7:0] pack_status(input nv_bits_t nv, input logic wel, input logic wip);
        return {nv.srwd, 3'b000, nv.bp, wel, wip};
    endfunction

endpackage

// File: rtl/sr_range_check.sv
module sr_range_check #(
    parameter int ADDR_W = 14
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    always_comb begin
        unique case (bp)
            2'b00:   in_range = 1'b0;
            2'b01:   in_range = addr[TOP] & addr[NXT];
            2'b10:   in_range = addr[TOP];
            default: in_range = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_cycle_timer.sv
module sr_cycle_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sr_serial_out.sv
module sr_serial_out #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              bit_o
);
    localparam int IW = $clog2(BYTE_W);
    localparam logic [IW-1:0] MSB_IDX = IW'(BYTE_W - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= MSB_IDX;
        end else if (start) begin
            idx_q <= MSB_IDX;
        end else if (shift) begin
            idx_q <= (idx_q == '0) ? MSB_IDX : idx_q - 1'b1;
        end
    end

    assign bit_o = byte_i[idx_q];
endmodule

// File: rtl/spi_wprot_ctrl.sv
module spi_wprot_ctrl
    import spi_wp_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WCYC_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              byte_aligned,
    input  logic              wp_n,
    input  logic              rd_start,
    input  logic              rd_shift,
    output logic              rd_bit,
    output logic [7:0]        status_byte,
    output logic              accept,
    output logic              reject,
    output logic              busy
);

    wp_state_e state_q, state_d;
    cmd_kind_e kind;
    nv_bits_t  nv_q, pend_q;
    logic      pend_vld_q;
    logic      wel_q;
    logic      accept_q, reject_q;
    logic      addr_prot, tmr_zero;
    logic      take, wtype, deny, accept_c, reject_c, cycle_done;

    sr_range_check #(.ADDR_W(ADDR_W)) i_range (
        .bp       (nv_q.bp),
        .addr     (cmd_addr),
        .in_range (addr_prot)
    );

    sr_cycle_timer #(.CYCLES(WCYC_CLKS)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept_c),
        .run   (state_q == ST_CYCLE),
        .zero  (tmr_zero)
    );

    sr_serial_out #(.BYTE_W(8)) i_serial (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rd_start),
        .shift  (rd_shift),
        .byte_i (status_byte),
        .bit_o  (rd_bit)
    );

    // Decision logic for one command event
    always_comb begin
        kind  = cmd_kind_e'(cmd_kind);
        take  = cmd_valid && (state_q == ST_READY);
        wtype = is_write_type(kind);
        deny  = !byte_aligned || !wel_q
              || ((kind == CMD_WRSR) && nv_q.srwd && !wp_n)
              || ((kind == CMD_ARRAY) && addr_prot)
              || (((kind == CMD_SECT) || (kind == CMD_LOCK)) && (nv_q.bp == 2'b11));
        accept_c   = take && wtype && !deny;
        reject_c   = take && wtype && deny;
        cycle_done = (state_q == ST_CYCLE) && tmr_zero;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (accept_c)   state_d = ST_CYCLE;
            ST_CYCLE: if (cycle_done) state_d = ST_READY;
            default:                  state_d = ST_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Register outputs and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q   <= 1'b0;
            reject_q   <= 1'b0;
            wel_q      <= 1'b0;
            nv_q       <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else begin
            accept_q <= accept_c;
            reject_q <= reject_c;
            if (reject_c) begin
                wel_q <= 1'b0;
            end else if (take && byte_aligned && kind == CMD_WREN) begin
                wel_q <= 1'b1;
            end else if (take && byte_aligned && kind == CMD_WRDI) begin
                wel_q <= 1'b0;
            end else if (cycle_done) begin
                wel_q <= 1'b0;
            end
            if (accept_c && kind == CMD_WRSR) begin
                pend_vld_q <= 1'b1;
                pend_q     <= '{srwd: cmd_data[SR_SRWD], bp: {cmd_data[SR_BP1], cmd_data[SR_BP0]}};
            end else if (cycle_done) begin
                pend_vld_q <= 1'b0;
                if (pend_vld_q) nv_q <= pend_q;
            end
        end
    end

    assign busy        = (state_q == ST_CYCLE);
    assign accept      = accept_q;
    assign reject      = reject_q;
    assign status_byte = pack_status(nv_q, wel_q, busy);

endmodule

// File: rtl/spi_wprot_ctrl_chk.sv
module spi_wprot_ctrl_chk #(
    parameter int ADDR_W    = 14,
    parameter int WCYC_CLKS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              byte_aligned,
    input logic              wp_n,
    input logic [7:0]        status_byte,
    input logic              accept,
    input logic              reject,
    input logic              busy
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6:4] == 3'b000);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (!accept && !reject));

    p_accept_starts_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> busy);

    p_cycle_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == WCYC_CLKS && !status_byte[1]));

    p_hw_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_kind == 3'd3 && status_byte[7] && !wp_n) |=> !accept);

    p_misaligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_kind >= 3'd3 && cmd_kind <= 3'd6 && !byte_aligned) |=> (reject && !status_byte[1]));

    p_no_wel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_kind >= 3'd3 && cmd_kind <= 3'd6 && !status_byte[1]) |=> !accept);

    p_full_protect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_kind == 3'd4 && status_byte[3:2] == 2'b11) |=> !accept);
endmodule

bind spi_wprot_ctrl spi_wprot_ctrl_chk #(.ADDR_W(ADDR_W), .WCYC_CLKS(WCYC_CLKS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_addr     (cmd_addr),
    .byte_aligned (byte_aligned),
    .wp_n         (wp_n),
    .status_byte  (status_byte),
    .accept       (accept),
    .reject       (reject),
    .busy         (busy)
);

// File: tb/test_spi_wprot_ctrl.sv
`timescale 1ns/1ps
module test_spi_wprot_ctrl;
    localparam int AW = 14;
    localparam int W  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_kind = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = 8'd0;
    logic          byte_aligned = 1'b1;
    logic          wp_n = 1'b1;
    logic          rd_start = 1'b0;
    logic          rd_shift = 1'b0;
    logic          rd_bit;
    logic [7:0]    status_byte;
    logic          accept, reject, busy;

    int total = 0;
    int bad = 0;

    logic       m_srwd = 1'b0;
    logic [1:0] m_bp   = 2'b00;
    logic       m_wel  = 1'b0;

    always #2 clk = ~clk;

    spi_wprot_ctrl #(.ADDR_W(AW), .WCYC_CLKS(W)) i_spi_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .byte_aligned(byte_aligned),
        .wp_n(wp_n), .rd_start(rd_start), .rd_shift(rd_shift), .rd_bit(rd_bit),
        .status_byte(status_byte), .accept(accept), .reject(reject), .busy(busy)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status(input logic wip);
        return {m_srwd, 3'b000, m_bp, m_wel, wip};
    endfunction

    function automatic logic in_prot(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 14'h3000;
            2'b10:   return a >= 14'h2000;
            default: return 1'b1;
        endcase
    endfunction

    // verdict: 0 silent, 1 accept, 2 reject; tag names the deciding requirement
    function automatic int decide(input logic [2:0] k, input logic [AW-1:0] a,
                                  input logic al, input logic wp, output string tag);
        tag = "R2";
        if (k < 3 || k > 6) return 0;
        if (!al)            begin tag = "R7";  return 2; end
        if (!m_wel)         begin tag = "R12"; return 2; end
        if (k == 3)         begin tag = "R4";  return (m_srwd && !wp) ? 2 : 1; end
        if (k == 4)         begin tag = "R5";  return in_prot(m_bp, a) ? 2 : 1; end
        tag = "R6";
        return (m_bp == 2'b11) ? 2 : 1;
    endfunction

    task automatic issue(input logic [2:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic al);
        string tag;
        int v;
        v = decide(k, a, al, wp_n, tag);
        cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_data = d; byte_aligned = al;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 3'd0; byte_aligned = 1'b1;
        check({6'd0, accept, reject}, {6'd0, v == 1, v == 2}, tag);
        if (v == 2) m_wel = 1'b0;
        if (v == 0 && al && k == 3'd1) m_wel = 1'b1;
        if (v == 0 && al && k == 3'd2) m_wel = 1'b0;
        check(status_byte, m_status(v == 1), (v == 2) ? "R10" : tag);
        if (v == 1) begin
            repeat (W - 1) @(negedge clk);
            check({7'd0, busy}, 8'd1, "R8");
            @(negedge clk);
            m_wel = 1'b0;
            if (k == 3'd3) begin m_srwd = d[7]; m_bp = d[3:2]; end
            check(status_byte, m_status(1'b0), (k == 3'd3) ? "R3" : "R8");
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status_byte, 8'h00, "R1");
        check({6'd0, accept, busy}, 8'h00, "R1");

        // R12: write without the latch armed
        issue(3'd4, 14'h0010, 8'h00, 1'b1);
        // R2: set and clear the latch, misaligned set is ignored
        issue(3'd1, 0, 0, 1'b0);
        issue(3'd1, 0, 0, 1'b1);
        issue(3'd2, 0, 0, 1'b1);
        // R7: misaligned write clears WEL
        issue(3'd1, 0, 0, 1'b1);
        issue(3'd4, 14'h0100, 0, 1'b0);
        // R3: status write with stray bits in the read-only positions
        issue(3'd1, 0, 0, 1'b1);
        issue(3'd3, 0, 8'h73, 1'b1);   // BP=00, reserved and WEL/WIP bits ignored
        issue(3'd1, 0, 0, 1'b1);
        issue(3'd3, 0, 8'h04, 1'b1);   // BP=01
        // R5: quarter boundary
        issue(3'd1, 0, 0, 1'b1); issue(3'd4, 14'h2FFF, 0, 1'b1);
        issue(3'd1, 0, 0, 1'b1); issue(3'd4, 14'h3000, 0, 1'b1);
        issue(3'd1, 0, 0, 1'b1); issue(3'd3, 0, 8'h08, 1'b1);   // BP=10
        issue(3'd1, 0, 0, 1'b1); issue(3'd4, 14'h1FFF, 0, 1'b1);
        issue(3'd1, 0, 0, 1'b1); issue(3'd4, 14'h2000, 0, 1'b1);
        issue(3'd1, 0, 0, 1'b1); issue(3'd3, 0, 8'h8C, 1'b1);   // SRWD=1, BP=11
        // R5/R6 full protection
        issue(3'd1, 0, 0, 1'b1); issue(3'd4, 14'h0000, 0, 1'b1);
        issue(3'd1, 0, 0, 1'b1); issue(3'd5, 14'h0000, 0, 1'b1);
        issue(3'd1, 0, 0, 1'b1); issue(3'd6, 14'h0000, 8'h02, 1'b1);
        // R4: hardware-protected mode
        wp_n = 1'b0;
        issue(3'd1, 0, 0, 1'b1); issue(3'd3, 0, 8'h00, 1'b1);
        check(status_byte, 8'h8C, "R4");
        wp_n = 1'b1;
        issue(3'd1, 0, 0, 1'b1); issue(3'd3, 0, 8'h00, 1'b1);
        check(status_byte, 8'h00, "R4");

        // R9: commands during a running cycle
        issue(3'd1, 0, 0, 1'b1);
        cmd_valid = 1'b1; cmd_kind = 3'd5; cmd_addr = 0;
        @(negedge clk);
        cmd_kind = 3'd2;                // clear-enable while busy
        @(negedge clk);
        check({6'd0, accept, reject}, 8'h00, "R9");
        cmd_kind = 3'd4;                // array write while busy
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 3'd0;
        @(negedge clk);
        check({6'd0, accept, reject}, 8'h00, "R9");
        check(status_byte, 8'h03, "R9");
        repeat (W) @(negedge clk);
        m_wel = 1'b0;
        check(status_byte, 8'h00, "R8");

        // R11: serial read-out with wrap
        issue(3'd1, 0, 0, 1'b1);
        issue(3'd3, 0, 8'h84, 1'b1);    // status 84h
        rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check({7'd0, rd_bit}, {7'd0, m_status(1'b0)[7 - (i % 8)]}, "R11");
            rd_shift = 1'b1; @(negedge clk); rd_shift = 1'b0;
        end
        issue(3'd1, 0, 0, 1'b1);
        issue(3'd3, 0, 8'h00, 1'b1);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] k;
            wp_n = ($urandom % 4) != 0;
            if (($urandom % 10) < 7) issue(3'd1, 0, 0, 1'b1);
            k = 3'($urandom % 8);
            issue(k, AW'($urandom), 8'($urandom), ($urandom % 8) != 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule